// File: doc/BRIEF.md
# Power-Saving Phase-Frequency Detector Core

This block is the digital heart of a frequency synthesizer. A reference signal and a feedback signal from the oscillator are both sampled on the system clock. Each is divided by its own programmable ratio, and a phase-frequency detector compares the two divided tick streams. The detector drives a three-state charge-pump command, made of an up strobe, a down strobe and an output enable. It also raises a lock flag once the phase error has stayed below one system-clock cycle for several reference periods.

A run-request input selects between normal operation and a low-power standby. In standby the pump command floats, so the external loop filter holds the oscillator where it was. The lock flag meanwhile reports the locked level. When operation resumes, both dividers and the detector start from a cleared state in the same cycle, so the first comparison sees only a small phase error. A sense input flips the pump command to suit an oscillator whose frequency falls as its control voltage rises.

Top module: `pfd_ps_core`

## Requirements
- R1: With `sense_pos_i` high, a reference tick that precedes the feedback tick makes `pump_up_o` and `pump_oe_o` high. A feedback tick that comes first makes `pump_dn_o` and `pump_oe_o` high. The drive is visible from the cycle after the leading tick up to and including the cycle of the lagging tick, so its width equals the tick separation in cycles.
- R2: With `sense_pos_i` low, the same situations drive the opposite strobe: a leading reference gives `pump_dn_o`, and a leading feedback gives `pump_up_o`.
- R3: When reference and feedback ticks land in the same cycle, `pump_oe_o`, `pump_up_o` and `pump_dn_o` all stay low, whatever the sense.
- R4: With `run_req_i` low, the cycle after it is sampled shows `pump_oe_o`, `pump_up_o` and `pump_dn_o` low and `lock_o` high. Input edges arriving in standby leave these outputs unchanged.
- R5: In the cycle where `run_req_i` is first sampled high, both dividers and the detector are cleared. The first tick of each path then falls on its Nth rising input edge sampled after that cycle, and this holds however far the paths had drifted before standby.
- R6: After reset the block sits in standby, with `pump_oe_o` low and `lock_o` high, until `run_req_i` is driven high.
- R7: `lock_o`, during operation, rises in the cycle after the fourth reference tick that has no pump strobe lasting two or more consecutive cycles since the last clear. It falls in the cycle after a strobe reaches its second consecutive high cycle.
- R8: A ratio of N ticks once every N rising edges, and 0 behaves as 1. A new ratio value is taken only when the current count finishes, never in the middle of a count.
- R9: `pump_up_o` and `pump_dn_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every input is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_in_i | input | 1 | Reference signal; rising edges are counted |
| fb_in_i | input | 1 | Oscillator feedback signal; rising edges are counted |
| run_req_i | input | 1 | High selects operation, low selects standby |
| sense_pos_i | input | 1 | High for positive oscillator slope, low to invert the pump sense |
| ref_ratio_i | input | DIV_W | Reference division ratio |
| fb_ratio_i | input | DIV_W | Feedback division ratio |
| pump_up_o | output | 1 | Pump source command |
| pump_dn_o | output | 1 | Pump sink command |
| pump_oe_o | output | 1 | Pump drive enable; low means the output floats |
| lock_o | output | 1 | Lock indication |

## Verification
Two events can fall in the same cycle: a reference tick and a feedback tick. When they do, the detector must cancel both strobes instead of driving either one. A second pair is a ratio write and a running count, because the new value must wait for the count to finish. The sweep sets division ratios and input periods so that the divided tick times either coincide exactly or are separated by a computed number of cycles, and it checks the float, drive and width of the first pulse against that arithmetic. A dedicated sequence writes a new feedback ratio in the middle of a count. The following coincident ticks must still float, and the later reference-leading pulse must start exactly where the old-then-new ratio schedule puts it.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  typedef enum logic {
    MODE_STBY = 1'b0,
    MODE_RUN  = 1'b1
  } mode_e;

  typedef struct packed {
    logic up;
    logic dn;
  } pump_t;

endpackage

// File: rtl/pfd_div.sv
module pfd_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             sig_i,
  input  logic [DIV_W-1:0] ratio_i,
  output logic             tick_o
);

  localparam int CW = DIV_W + 1;

  logic             sig_q;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] act_q, act_d;
  logic             rise;
  logic             term;

  assign rise = sig_i & ~sig_q;
  assign term = ({1'b0, cnt_q} + CW'(1)) >= {1'b0, act_q};

  always_comb begin
    cnt_d  = cnt_q;
    act_d  = act_q;
    tick_o = 1'b0;
    if (!run_i) begin
      cnt_d = '0;
      act_d = ratio_i;
    end else if (rise) begin
      if (term) begin
        tick_o = 1'b1;
        cnt_d  = '0;
        act_d  = ratio_i;
      end else begin
        cnt_d = cnt_q + DIV_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig_q <= 1'b0;
      cnt_q <= '0;
      act_q <= '0;
    end else begin
      sig_q <= sig_i;
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  // R8
  ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && $past(run_i) && cnt_q != '0) |-> $stable(act_q));

  // R5
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (cnt_q == '0));

endmodule

// File: rtl/pfd_det.sv
module pfd_det
  import pfd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  run_i,
  input  logic  ref_tick_i,
  input  logic  fb_tick_i,
  output pump_t pump_o
);

  pump_t pump_q, pump_d;
  logic  up_n, dn_n;

  always_comb begin
    up_n   = pump_q.up | ref_tick_i;
    dn_n   = pump_q.dn | fb_tick_i;
    pump_d = '{up: up_n, dn: dn_n};
    if (!run_i || (up_n && dn_n)) begin
      pump_d = '{up: 1'b0, dn: 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pump_q <= '{up: 1'b0, dn: 1'b0};
    end else begin
      pump_q <= pump_d;
    end
  end

  assign pump_o = pump_q;

  // R9
  up_dn_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pump_q.up && pump_q.dn));

  // R3
  match_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_tick_i && fb_tick_i) |=> (!pump_q.up && !pump_q.dn));

endmodule

// File: rtl/pfd_lock.sv
module pfd_lock
  import pfd_pkg::*;
#(
  parameter int LOCK_N = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  run_i,
  input  logic  ref_tick_i,
  input  pump_t pump_i,
  output logic  locked_o
);

  localparam int CNT_W = $clog2(LOCK_N + 1);

  pump_t            prev_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wide;
  logic             full;

  assign wide = run_i & ((pump_i.up & prev_q.up) | (pump_i.dn & prev_q.dn));
  assign full = (cnt_q == CNT_W'(LOCK_N));

  always_comb begin
    cnt_d = cnt_q;
    if (wide) begin
      cnt_d = '0;
    end else if (run_i && ref_tick_i && !full) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '{up: 1'b0, dn: 1'b0};
      cnt_q  <= '0;
    end else begin
      prev_q <= pump_i;
      cnt_q  <= cnt_d;
    end
  end

  assign locked_o = full;

  // R7
  wide_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wide |=> !locked_o);

  // R7
  lock_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_o) |-> $past(ref_tick_i));

endmodule

// File: rtl/pfd_ps_core.sv
module pfd_ps_core
  import pfd_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int LOCK_N = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_in_i,
  input  logic             fb_in_i,
  input  logic             run_req_i,
  input  logic             sense_pos_i,
  input  logic [DIV_W-1:0] ref_ratio_i,
  input  logic [DIV_W-1:0] fb_ratio_i,
  output logic             pump_up_o,
  output logic             pump_dn_o,
  output logic             pump_oe_o,
  output logic             lock_o
);

  localparam int N_PATH = 2;

  logic             rst_meta, rst_s;
  mode_e            mode_q, mode_d;
  logic             run;
  logic [N_PATH-1:0] sig_in;
  logic [N_PATH-1:0] tick;
  logic [DIV_W-1:0] ratio_arr [N_PATH];
  pump_t            pump;
  logic             locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  always_comb begin
    mode_d = run_req_i ? MODE_RUN : MODE_STBY;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      mode_q <= MODE_STBY;
    end else begin
      mode_q <= mode_d;
    end
  end

  assign run          = (mode_q == MODE_RUN);
  assign sig_in       = {fb_in_i, ref_in_i};
  assign ratio_arr[0] = ref_ratio_i;
  assign ratio_arr[1] = fb_ratio_i;

  for (genvar g = 0; g < N_PATH; g++) begin : g_path
    pfd_div #(.DIV_W(DIV_W)) u_div (
      .clk     (clk),
      .rst_n   (rst_s),
      .run_i   (run),
      .sig_i   (sig_in[g]),
      .ratio_i (ratio_arr[g]),
      .tick_o  (tick[g])
    );
  end

  pfd_det u_det (
    .clk        (clk),
    .rst_n      (rst_s),
    .run_i      (run),
    .ref_tick_i (tick[0]),
    .fb_tick_i  (tick[1]),
    .pump_o     (pump)
  );

  pfd_lock #(.LOCK_N(LOCK_N)) u_lock (
    .clk        (clk),
    .rst_n      (rst_s),
    .run_i      (run),
    .ref_tick_i (tick[0]),
    .pump_i     (pump),
    .locked_o   (locked)
  );

  always_comb begin
    pump_oe_o = run & (pump.up | pump.dn);
    pump_up_o = run & (sense_pos_i ? pump.up : pump.dn);
    pump_dn_o = run & (sense_pos_i ? pump.dn : pump.up);
    lock_o    = ~run | locked;
  end

  // R4
  standby_float_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !run_req_i |=> (!pump_oe_o && !pump_up_o && !pump_dn_o && lock_o));

  // R9
  port_excl_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !(pump_up_o && pump_dn_o));

  // R5
  resume_quiet_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (run_req_i && !run) |=> !pump_oe_o);

endmodule

// File: tb/pfd_ps_core_bench.sv
module pfd_ps_core_bench;

  localparam int DIV_W = 8;
  localparam int MAX_CYC = 200000;

  logic             clk;
  logic             rst_n;
  logic             ref_in_i, fb_in_i, run_req_i, sense_pos_i;
  logic [DIV_W-1:0] ref_ratio_i, fb_ratio_i;
  logic             pump_up_o, pump_dn_o, pump_oe_o, lock_o;

  int n_chk;
  int n_fail;
  int cyc;
  int base;
  int rp;
  int vp;
  bit done;

  pfd_ps_core #(.DIV_W(DIV_W), .LOCK_N(4)) u_pfd_ps_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .ref_in_i    (ref_in_i),
    .fb_in_i     (fb_in_i),
    .run_req_i   (run_req_i),
    .sense_pos_i (sense_pos_i),
    .ref_ratio_i (ref_ratio_i),
    .fb_ratio_i  (fb_ratio_i),
    .pump_up_o   (pump_up_o),
    .pump_dn_o   (pump_dn_o),
    .pump_oe_o   (pump_oe_o),
    .lock_o      (lock_o)
  );

  initial begin
    clk = 1'b0;
    forever #5 clk = ~clk;
  end

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s cycle %0d actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  task automatic next_cyc();
    @(negedge clk);
    cyc++;
    ref_in_i = (cyc > base) && (((cyc - base) % rp) == 0);
    fb_in_i  = (cyc > base) && (((cyc - base) % vp) == 0);
  endtask

  function automatic int outs();
    return int'({pump_oe_o, pump_up_o, pump_dn_o});
  endfunction

  task automatic do_reset();
    rst_n     = 1'b0;
    run_req_i = 1'b0;
    repeat (3) next_cyc();
    rst_n = 1'b1;
    repeat (4) next_cyc();
    // R6: standby after reset
    chk(outs() == 0 && lock_o, "R6", outs() * 2 + int'(lock_o), 1);
  endtask

  task automatic start_run(output int s);
    base = cyc + 1;
    next_cyc();
    run_req_i = 1'b1;
    s = cyc;
  endtask

  task automatic run_case(int rr, int cr, int p_r, int p_v, bit pol);
    int s, er, tr, tv, lo, hi, last, tlock, expv;
    bit eq, e_oe, e_up, e_dn, e_lk;
    string tag;
    rp = p_r;
    vp = p_v;
    ref_ratio_i = DIV_W'(rr);
    fb_ratio_i  = DIV_W'(cr);
    sense_pos_i = pol;
    do_reset();
    start_run(s);
    er    = (rr == 0) ? 1 : rr;
    tr    = s + er * p_r;
    tv    = s + cr * p_v;
    eq    = (tr == tv);
    lo    = (tr < tv) ? tr : tv;
    hi    = (tr < tv) ? tv : tr;
    tlock = s + 4 * er * p_r + 1;
    last  = eq ? tlock : hi + 1;
    tag   = eq ? "R3" : ((rr == 0) ? "R8" : (pol ? "R1" : "R2"));
    while (cyc < last) begin
      next_cyc();
      e_oe = !eq && (cyc > lo) && (cyc <= hi);
      e_up = e_oe && ((tr < tv) == pol);
      e_dn = e_oe && !e_up;
      expv = int'({e_oe, e_up, e_dn});
      chk(outs() == expv, tag, outs(), expv);
      if (eq) begin
        e_lk = (cyc >= tlock);
        chk(lock_o == e_lk, "R7", int'(lock_o), int'(e_lk));
      end
    end
  endtask

  task automatic ratio_change_test();
    int s;
    rp = 4;
    vp = 4;
    ref_ratio_i = 8'd2;
    fb_ratio_i  = 8'd2;
    sense_pos_i = 1'b1;
    do_reset();
    start_run(s);
    while (cyc < s + 52) begin
      next_cyc();
      if (cyc == s + 33) chk(lock_o, "R7", int'(lock_o), 1);
      if (cyc == s + 37) fb_ratio_i = 8'd3;
      if (cyc == s + 41) chk(outs() == 0, "R8", outs(), 0);
      if (cyc == s + 48) chk(outs() == 0, "R8", outs(), 0);
      if (cyc == s + 49) chk(outs() == 6, "R8", outs(), 6);
      if (cyc == s + 50) chk(lock_o, "R7", int'(lock_o), 1);
      if (cyc == s + 51) chk(!lock_o, "R7", int'(lock_o), 0);
    end
  endtask

  task automatic standby_test();
    int s, s2;
    rp = 4;
    vp = 4;
    ref_ratio_i = 8'd1;
    fb_ratio_i  = 8'd2;
    sense_pos_i = 1'b1;
    do_reset();
    start_run(s);
    while (cyc < s + 6) begin
      next_cyc();
      if (cyc == s + 5) chk(outs() == 6, "R1", outs(), 6);
    end
    run_req_i = 1'b0;
    next_cyc();
    // R4: floats and reports lock in standby, edges ignored
    for (int k = 0; k < 20; k++) begin
      chk(outs() == 0 && lock_o, "R4", outs() * 2 + int'(lock_o), 1);
      next_cyc();
    end
    start_run(s2);
    while (cyc < s2 + 10) begin
      next_cyc();
      if (cyc == s2 + 1) chk(!lock_o, "R5", int'(lock_o), 0);
      if (cyc <= s2 + 4 || cyc >= s2 + 9)
        chk(outs() == 0, "R5", outs(), 0);
      else
        chk(outs() == 6, "R5", outs(), 6);
    end
  endtask

  initial begin
    n_chk     = 0;
    n_fail    = 0;
    cyc       = 0;
    base      = 0;
    rp        = 2;
    vp        = 2;
    done      = 1'b0;
    rst_n     = 1'b0;
    ref_in_i  = 1'b0;
    fb_in_i   = 1'b0;
    run_req_i = 1'b0;
    sense_pos_i = 1'b1;
    ref_ratio_i = '0;
    fb_ratio_i  = '0;
    for (int rr = 0; rr < 4; rr++)
      for (int cr = 1; cr < 4; cr++)
        for (int pr = 2; pr < 5; pr++)
          for (int pv = 2; pv < 5; pv++)
            for (int pol = 0; pol < 2; pol++)
              run_case(rr, cr, pr, pv, bit'(pol));
    ratio_change_test();
    standby_test();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(10 * MAX_CYC);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, MAX_CYC);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule